// File: doc/BRIEF.md
# Bit Test-and-Modify Execution Unit

This unit carries out the four bit-test instructions of a general-purpose integer pipeline. It inspects one bit of an operand and may then modify it. The decode stage hands it the operand value and a bit number taken from a register. It also passes an operand-size select, a flag saying whether the operand lives in memory, the operand's base address and a two-bit operation code. One cycle after a start strobe the unit returns three things. The carry output holds the bit as it was before any change. The result output holds the modified operand, with a write-enable for the three forms that store a result. The address output holds the effective address of the operand word that was actually addressed.

A register bit number may be larger than the operand width. For a register operand the excess is discarded, because only the number modulo the width picks the bit. For a memory operand the quotient of the bit number by the width moves the address by whole operand words, expressed in bytes. This lets software treat memory as one long bit string. Fetching and storing memory, and every other flag, stay with the surrounding pipeline.

The controller has two states. `ST_IDLE` is the state after reset and the state reached whenever a cycle passes without a start. `ST_DONE` is the state entered on the clock edge that samples `start` high. The transitions are named *launch* (from `ST_IDLE` to `ST_DONE` on start), *retire* (from `ST_DONE` to `ST_IDLE` without start) and *chain* (from `ST_DONE` back to `ST_DONE` when start is high again).

Top module: `bit_modify_unit`

## Requirements
- R1: While reset is held and after its release, `done`, `wr_en`, `carry`, `result` and `eff_addr` are all zero until the first start.
- R2: `done` is high in exactly the cycle after each cycle in which `start` is sampled high, and low otherwise.
- R3: `wide` = 1 selects a 32-bit operand. `wide` = 0 selects a 16-bit operand taken from `operand[15:0]`, and then `result[31:16]` is zero.
- R4: The bit position is the bit number modulo the operand width. For a 32-bit operand the bit number is all of `bit_num`. For a 16-bit operand it is `bit_num[15:0]`, an unsigned value.
- R5: `carry` equals the selected bit of the operand before modification.
- R6: The operation code selects the form. 0 is test, and the result equals the operand. 1 is set, and the bit is forced to one. 2 is reset, and the bit is forced to zero. 3 is complement, and the bit is inverted. All other bits are left as they were.
- R7: `wr_en` is high together with `done` for codes 1, 2 and 3. It is never high for code 0, and it is never high without `done`.
- R8: With `is_mem` = 1, `eff_addr` = `base_addr` + (bit number / width) × (width / 8), with the bit number taken as in R4 and the sum wrapping modulo 2^32.
- R9: With `is_mem` = 0, `eff_addr` equals `base_addr` whatever the bit number is.
- R10: `carry`, `result` and `eff_addr` keep their values over any cycle in which `start` is low, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start strobe; the inputs below are sampled with it |
| op | input | 2 | Operation: 0 test, 1 set, 2 reset, 3 complement |
| wide | input | 1 | 1 = 32-bit operand, 0 = 16-bit operand |
| is_mem | input | 1 | 1 = operand is in memory, so the address is displaced |
| operand | input | 32 | Operand value as read |
| bit_num | input | 32 | Bit number from the register operand |
| base_addr | input | 32 | Effective address of the memory operand before displacement |
| done | output | 1 | Outputs valid, one cycle after start |
| carry | output | 1 | Original value of the selected bit |
| result | output | 32 | Operand after the operation |
| wr_en | output | 1 | Result must be written back |
| eff_addr | output | 32 | Address of the addressed operand word |

## Verification
The bench builds the unit with its default parameters: a 32-bit wide form, a 16-bit narrow form and 32-bit addresses. With these defaults the sweep reaches every bit position of both widths and displacements of several words in each width. It also exercises bit numbers whose upper half must be dropped in the narrow form and an address sum that wraps past the top of the address space. Every operation code is swept against both operand widths and both operand locations, with back-to-back starts and an idle cycle that checks the outputs hold.

// File: rtl/bitop_pkg.sv
package bitop_pkg;

    typedef enum logic [1:0] {
        BOP_TEST = 2'd0,
        BOP_SET  = 2'd1,
        BOP_CLR  = 2'd2,
        BOP_FLIP = 2'd3
    } bop_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_DONE = 1'b1
    } bop_state_e;

endpackage

// File: rtl/bitop_locate.sv
module bitop_locate #(
    parameter int DATA_W   = 32,
    parameter int NARROW_W = 16,
    parameter int ADDR_W   = 32,
    localparam int IDX_W   = $clog2(DATA_W)
) (
    input  logic              wide,
    input  logic              is_mem,
    input  logic [DATA_W-1:0] bit_num,
    input  logic [ADDR_W-1:0] base_addr,
    output logic [IDX_W-1:0]  pos,
    output logic [ADDR_W-1:0] eff_addr
);
    // widths are powers of two of at least one byte
    localparam int WSH = $clog2(DATA_W);
    localparam int NSH = $clog2(NARROW_W);
    localparam int WB  = WSH - 3;
    localparam int NB  = NSH - 3;

    logic [DATA_W-1:0] nar_num;
    logic [DATA_W-1:0] word_idx;
    logic [ADDR_W-1:0] disp;

    always_comb begin
        nar_num = {{(DATA_W-NARROW_W){1'b0}}, bit_num[NARROW_W-1:0]};
        if (wide) begin
            pos      = bit_num[IDX_W-1:0];
            word_idx = bit_num >> WSH;
            disp     = ADDR_W'(word_idx) << WB;
        end else begin
            pos      = IDX_W'(bit_num[NSH-1:0]);
            word_idx = nar_num >> NSH;
            disp     = ADDR_W'(word_idx) << NB;
        end
        eff_addr = is_mem ? (base_addr + disp) : base_addr;
    end

endmodule

// File: rtl/bitop_alu.sv
module bitop_alu
    import bitop_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int NARROW_W = 16,
    localparam int IDX_W   = $clog2(DATA_W)
) (
    input  bop_e              op,
    input  logic              wide,
    input  logic [DATA_W-1:0] operand,
    input  logic [IDX_W-1:0]  pos,
    output logic              old_bit,
    output logic [DATA_W-1:0] new_val,
    output logic              writes
);
    logic [DATA_W-1:0] src;
    logic [DATA_W-1:0] mask;

    always_comb begin
        src     = wide ? operand
                       : {{(DATA_W-NARROW_W){1'b0}}, operand[NARROW_W-1:0]};
        mask    = {{(DATA_W-1){1'b0}}, 1'b1} << pos;
        old_bit = src[pos];
        unique case (op)
            BOP_TEST: new_val = src;
            BOP_SET:  new_val = src | mask;
            BOP_CLR:  new_val = src & ~mask;
            BOP_FLIP: new_val = src ^ mask;
            default:  new_val = src;
        endcase
        writes = (op != BOP_TEST);
    end

endmodule

// File: rtl/bitop_ctrl.sv
module bitop_ctrl
    import bitop_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic done,
    output logic capture
);
    bop_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_DONE;            // launch
            ST_DONE: state_d = start ? ST_DONE : ST_IDLE;     // chain / retire
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        done    = (state_q == ST_DONE);
        capture = start;
    end

    AST_DONE_FOLLOWS_START: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> done);                                      // R2
    AST_DONE_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> !done);                                    // R2

endmodule

// File: rtl/bit_modify_unit.sv
module bit_modify_unit
    import bitop_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int NARROW_W = 16,
    parameter int ADDR_W   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        op,
    input  logic              wide,
    input  logic              is_mem,
    input  logic [DATA_W-1:0] operand,
    input  logic [DATA_W-1:0] bit_num,
    input  logic [ADDR_W-1:0] base_addr,
    output logic              done,
    output logic              carry,
    output logic [DATA_W-1:0] result,
    output logic              wr_en,
    output logic [ADDR_W-1:0] eff_addr
);
    localparam int IDX_W = $clog2(DATA_W);

    logic [IDX_W-1:0]  pos;
    logic [ADDR_W-1:0] addr_c;
    logic              old_bit_c;
    logic [DATA_W-1:0] new_val_c;
    logic              writes_c;
    logic              capture;
    logic              writes_q;
    bop_e              op_e;

    assign op_e = bop_e'(op);

    bitop_locate #(.DATA_W(DATA_W), .NARROW_W(NARROW_W), .ADDR_W(ADDR_W)) locate_i (
        .wide(wide), .is_mem(is_mem), .bit_num(bit_num),
        .base_addr(base_addr), .pos(pos), .eff_addr(addr_c)
    );

    bitop_alu #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) alu_i (
        .op(op_e), .wide(wide), .operand(operand), .pos(pos),
        .old_bit(old_bit_c), .new_val(new_val_c), .writes(writes_c)
    );

    bitop_ctrl ctrl_i (
        .clk(clk), .rst_n(rst_n), .start(start),
        .done(done), .capture(capture)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            carry    <= 1'b0;
            result   <= '0;
            writes_q <= 1'b0;
            eff_addr <= '0;
        end else if (capture) begin
            carry    <= old_bit_c;
            result   <= new_val_c;
            writes_q <= writes_c;
            eff_addr <= addr_c;
        end
    end

    assign wr_en = done & writes_q;

    AST_WRITE_ONLY_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> done);                                      // R7
    AST_TEST_NEVER_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
        (start && op == 2'd0) |=> !wr_en);                    // R7
    AST_MODIFY_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
        (start && op != 2'd0) |=> wr_en);                     // R7
    AST_REG_ADDR_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !is_mem) |=> eff_addr == $past(base_addr)); // R9
    AST_NARROW_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !wide) |=> result[DATA_W-1:NARROW_W] == '0); // R3
    AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> ($stable(result) && $stable(carry) && $stable(eff_addr))); // R10

endmodule

// File: tb/bit_modify_unit_tb_top.sv
module bit_modify_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  op = 2'd0;
    logic        wide = 1'b0;
    logic        is_mem = 1'b0;
    logic [31:0] operand = '0;
    logic [31:0] bit_num = '0;
    logic [31:0] base_addr = '0;
    logic        done, carry, wr_en;
    logic [31:0] result, eff_addr;

    int n_run = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    bit_modify_unit dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .wide(wide),
        .is_mem(is_mem), .operand(operand), .bit_num(bit_num),
        .base_addr(base_addr), .done(done), .carry(carry), .result(result),
        .wr_en(wr_en), .eff_addr(eff_addr)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : stim
        logic [31:0] e_src, e_mask, e_res, e_disp, e_addr, bn, nbn, hold_res, hold_addr;
        logic        e_carry, hold_c;
        int          p;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 done", {31'b0, done}, 32'd0);
        chk("R1 wr_en", {31'b0, wr_en}, 32'd0);
        chk("R1 carry", {31'b0, carry}, 32'd0);
        chk("R1 result", result, 32'd0);
        chk("R1 eff_addr", eff_addr, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after release", {31'b0, done}, 32'd0);
        chk("R1 result after release", result, 32'd0);

        for (int w = 0; w < 2; w++) begin
            for (int m = 0; m < 2; m++) begin
                for (int o = 0; o < 4; o++) begin
                    for (int k = 0; k < 84; k++) begin
                        if (k < 80)       bn = 32'(k);
                        else if (k == 80) bn = 32'hFFFF_FFFF;
                        else if (k == 81) bn = 32'h0001_0013;
                        else if (k == 82) bn = 32'h8000_0020;
                        else              bn = 32'h0000_0050;
                        wide      = w[0];
                        is_mem    = m[0];
                        op        = o[1:0];
                        bit_num   = bn;
                        operand   = 32'hA5C3_0F96 ^ (bn * 32'h9E37_79B9) ^ 32'(o * 32'h1111);
                        base_addr = (k >= 80) ? 32'hFFFF_FFF0 : 32'h0000_4000 + 32'(k * 3);
                        start     = 1'b1;
                        // expected values from the requirements
                        nbn    = {16'h0, bn[15:0]};
                        e_src  = w[0] ? operand : {16'h0, operand[15:0]};
                        p      = w[0] ? int'(bn % 32) : int'(nbn % 16);
                        e_mask = 32'd1 << p;
                        e_carry = e_src[p];
                        case (o)
                            0: e_res = e_src;
                            1: e_res = e_src | e_mask;
                            2: e_res = e_src & ~e_mask;
                            default: e_res = e_src ^ e_mask;
                        endcase
                        e_disp = w[0] ? (bn / 32) * 4 : (nbn / 16) * 2;
                        e_addr = m[0] ? base_addr + e_disp : base_addr;
                        @(negedge clk);
                        start = 1'b0;
                        chk("R2 done", {31'b0, done}, 32'd1);
                        chk("R5 carry", {31'b0, carry}, {31'b0, e_carry});
                        chk("R6 R4 R3 result", result, e_res);
                        chk("R7 wr_en", {31'b0, wr_en}, (o != 0) ? 32'd1 : 32'd0);
                        if (m != 0) chk("R8 eff_addr", eff_addr, e_addr);
                        else        chk("R9 eff_addr", eff_addr, e_addr);
                        if (k % 8 == 7) begin
                            // R10: idle cycle with scrambled inputs
                            hold_res = result; hold_addr = eff_addr; hold_c = carry;
                            operand = ~operand; bit_num = ~bit_num;
                            base_addr = ~base_addr; op = ~op;
                            wide = ~wide; is_mem = ~is_mem;
                            @(negedge clk);
                            chk("R2 done drops", {31'b0, done}, 32'd0);
                            chk("R7 no write idle", {31'b0, wr_en}, 32'd0);
                            chk("R10 result hold", result, hold_res);
                            chk("R10 addr hold", eff_addr, hold_addr);
                            chk("R10 carry hold", {31'b0, carry}, {31'b0, hold_c});
                        end
                    end
                end
            end
        end
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule